// File: doc/BRIEF.md
# General-purpose output port with per-bit set, clear and toggle

This block is a 24-pin general-purpose port. Each pin has an output data latch and a direction bit. Software updates the latch through a small register bus. A data register loads all latch bits in one write. Three write-only command registers change only the bits written as 1: one forces them high, one forces them low and one inverts them. Each command write is a single atomic update, so no read-modify-write is needed and no other bit can be disturbed.

A pad is driven only when its direction bit selects output. The latch still follows every command while its pin is an input, so a value can be prepared before the pin is turned into an output. Reading the data register returns the pad levels after a two-flop synchroniser.

Top module: `gpio_latch_port`

## Requirements
- R1: After reset the latch and the direction register are all zeros, `pad_oe_o` and `pad_out_o` are zero, and every readable register returns 0.
- R2: A write to the set register (word address 2) forces to 1 each latch bit i for which write data bit i is 1. Latch bits written as 0 keep their value.
- R3: A write to the clear register (word address 3) forces to 0 each latch bit i for which write data bit i is 1. Latch bits written as 0 keep their value.
- R4: A write to the toggle register (word address 4) inverts each latch bit i for which write data bit i is 1. Latch bits written as 0 keep their value.
- R5: A write to the data register (word address 0) loads write data bits 23..0 into the latch. Pin i maps to bit i. Write data bits 31..24 are ignored for every register.
- R6: Reads of the set, clear and toggle registers return 0. Reads of the unmapped word addresses 5 to 7 also return 0.
- R7: The latch updates whether or not its pin is an output. `pad_oe_o[i]` equals direction bit i. `pad_out_o[i]` equals latch bit i when direction bit i is 1, and 0 when it is 0.
- R8: A read of the data register returns `pad_in_i` sampled through two flops. A pad change is not visible after the first rising clock edge and is visible after the second.
- R9: The direction register (word address 1, 1 = output) reads back its 24 bits. Read-data bits 31..24 are always 0.
- R10: A write takes effect at the rising edge where `we_i` is high, and it touches only the one addressed register. With `we_i` low, the latch and the direction register hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Word address of the register accessed |
| we_i | input | 1 | Write enable, one write per cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| pad_in_i | input | 24 | Pad levels, asynchronous |
| pad_oe_o | output | 24 | Per-pin output enable |
| pad_out_o | output | 24 | Per-pin output value, gated by the enable |

## Verification
The latch assertions take for granted that a write selects one register and that `wdata_i` is stable around the rising edge. The stimulus meets this by driving the bus only on falling edges and holding `we_i` high for exactly one cycle per write. The pad inputs are likewise changed only on falling edges, so the two-flop latency can be counted in whole cycles. The assertions expect no bus activity during reset, and the bench issues its first write only after reset is released.

// File: rtl/gpio_latch_pkg.sv
package gpio_latch_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIR  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_SET  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CLR  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_TGL  = 3'd4;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_DATA = 3'd1,
    SEL_DIR  = 3'd2,
    SEL_SET  = 3'd3,
    SEL_CLR  = 3'd4,
    SEL_TGL  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_latch_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output reg_sel_e          sel_o,
  output logic              wr_data_o,
  output logic              wr_dir_o,
  output logic              wr_set_o,
  output logic              wr_clr_o,
  output logic              wr_tgl_o
);
  always_comb begin
    unique case (addr_i)
      ADDR_DATA: sel_o = SEL_DATA;
      ADDR_DIR:  sel_o = SEL_DIR;
      ADDR_SET:  sel_o = SEL_SET;
      ADDR_CLR:  sel_o = SEL_CLR;
      ADDR_TGL:  sel_o = SEL_TGL;
      default:   sel_o = SEL_NONE;
    endcase
  end

  assign wr_data_o = we_i && (sel_o == SEL_DATA);
  assign wr_dir_o  = we_i && (sel_o == SEL_DIR);
  assign wr_set_o  = we_i && (sel_o == SEL_SET);
  assign wr_clr_o  = we_i && (sel_o == SEL_CLR);
  assign wr_tgl_o  = we_i && (sel_o == SEL_TGL);

  // R10: a write strobes at most one register
  always_comb begin
    if (we_i) one_strobe_chk: assert ($onehot0({wr_data_o, wr_dir_o, wr_set_o, wr_clr_o, wr_tgl_o}));
  end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int unsigned NUM_PINS = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_data_i,
  input  logic                wr_dir_i,
  input  logic                wr_set_i,
  input  logic                wr_clr_i,
  input  logic                wr_tgl_i,
  input  logic [NUM_PINS-1:0] wd_i,
  output logic [NUM_PINS-1:0] latch_o,
  output logic [NUM_PINS-1:0] dir_o
);
  logic [NUM_PINS-1:0] dir_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   bit_q <= 1'b0;
      else if (wr_data_i)            bit_q <= wd_i[i];
      else if (wr_set_i && wd_i[i])  bit_q <= 1'b1;
      else if (wr_clr_i && wd_i[i])  bit_q <= 1'b0;
      else if (wr_tgl_i && wd_i[i])  bit_q <= ~bit_q;
    end
    assign latch_o[i] = bit_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dir_q <= '0;
    else if (wr_dir_i) dir_q <= wd_i;
  end
  assign dir_o = dir_q;

  // R2
  set_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set_i |=> ((latch_o & $past(wd_i)) == $past(wd_i)) &&
                 ((latch_o & ~$past(wd_i)) == ($past(latch_o) & ~$past(wd_i))));
  // R3
  clr_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr_i |=> ((latch_o & $past(wd_i)) == '0) &&
                 ((latch_o & ~$past(wd_i)) == ($past(latch_o) & ~$past(wd_i))));
  // R4
  tgl_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tgl_i |=> ((latch_o ^ $past(latch_o)) == $past(wd_i)));
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_data_i || wr_set_i || wr_clr_i || wr_tgl_i) |=> $stable(latch_o));
  // R10
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_dir_i |=> $stable(dir_o));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NUM_PINS = 24,
  parameter int unsigned STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] sync_o
);
  logic [NUM_PINS-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= pad_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_latch_port.sv
module gpio_latch_port
  import gpio_latch_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_out_o
);
  localparam int unsigned RES_W = DATA_W - NUM_PINS;

  reg_sel_e            sel;
  logic                wr_data, wr_dir, wr_set, wr_clr, wr_tgl;
  logic [NUM_PINS-1:0] latch, dir, pad_sync;
  logic [NUM_PINS-1:0] wd_pins;
  logic [RES_W-1:0]    wd_res;

  assign wd_pins = wdata_i[NUM_PINS-1:0];
  assign wd_res  = wdata_i[DATA_W-1:NUM_PINS];

  gpio_reg_decode u_dec (
    .addr_i    (addr_i),
    .we_i      (we_i),
    .sel_o     (sel),
    .wr_data_o (wr_data),
    .wr_dir_o  (wr_dir),
    .wr_set_o  (wr_set),
    .wr_clr_o  (wr_clr),
    .wr_tgl_o  (wr_tgl)
  );

  gpio_out_latch #(.NUM_PINS(NUM_PINS)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_data_i (wr_data),
    .wr_dir_i  (wr_dir),
    .wr_set_i  (wr_set),
    .wr_clr_i  (wr_clr),
    .wr_tgl_i  (wr_tgl),
    .wd_i      (wd_pins),
    .latch_o   (latch),
    .dir_o     (dir)
  );

  gpio_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_LEN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pad_i  (pad_in_i),
    .sync_o (pad_sync)
  );

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_DATA: rdata_o[NUM_PINS-1:0] = pad_sync;
      SEL_DIR:  rdata_o[NUM_PINS-1:0] = dir;
      default:  rdata_o = '0;
    endcase
  end

  assign pad_oe_o  = dir;
  assign pad_out_o = latch & dir;

  // R7: no undriven pin shows a high output value
  gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & ~pad_oe_o) == '0);
  // R6
  cmd_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= ADDR_SET) |-> (rdata_o == '0));
  // R9
  res_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:NUM_PINS] == '0);
  // R5: reserved write bits leave the set result to the pin field alone
  res_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_set && (wd_res != '0)) |=> (latch == ($past(latch) | $past(wd_pins))));
endmodule

// File: tb/gpio_latch_port_test.sv
module gpio_latch_port_test;
  localparam int N = 24;
  localparam int NV = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_oe, pad_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_latch_port uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_oe_o(pad_oe), .pad_out_o(pad_out)
  );

  // address, write data, expected latch (seen on pad_out with all pins output)
  localparam logic [2:0]  V_ADDR [NV] = '{3'd0, 3'd2, 3'd3, 3'd4, 3'd2,
                                          3'd3, 3'd4, 3'd0, 3'd3, 3'd4};
  localparam logic [31:0] V_WD   [NV] = '{32'h00A5A5A5, 32'h0000000F, 32'h000000F0,
                                          32'h00FFFFFF, 32'hFF000000, 32'h00000000,
                                          32'h00800001, 32'hFFFFFFFF, 32'h00123456,
                                          32'h00000000};
  localparam logic [N-1:0] V_EXP [NV] = '{24'hA5A5A5, 24'hA5A5AF, 24'hA5A50F,
                                          24'h5A5AF0, 24'h5A5AF0, 24'h5A5AF0,
                                          24'hDA5AF1, 24'hFFFFFF, 24'hEDCBA9,
                                          24'hEDCBA9};
  localparam string V_REQ [NV] = '{"R5", "R2", "R3", "R4", "R5",
                                   "R3", "R4", "R5", "R3", "R4"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; we = 1'b0;
    #1;
    d = rdata;
  endtask

  initial begin : watchdog
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    pad_in = 24'h0;
    #35 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 oe", 32'(pad_oe), 32'h0);
    check("R1 out", 32'(pad_out), 32'h0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), r);
      check("R1 read", r, 32'h0);
    end

    // R7 latch moves while pins are inputs
    wr(3'd2, 32'h00000003);
    check("R7 undriven", 32'(pad_out), 32'h0);
    check("R7 oe", 32'(pad_oe), 32'h0);
    wr(3'd1, 32'h00000001);
    check("R7 oe bit0", 32'(pad_oe), 32'h1);
    check("R7 out bit0", 32'(pad_out), 32'h1);
    wr(3'd1, 32'h00000002);
    check("R7 out bit1", 32'(pad_out), 32'h2);

    // R9 direction readback, reserved write bits dropped
    wr(3'd1, 32'hFFFFFFFF);
    rd(3'd1, r);
    check("R9 dir read", r, 32'h00FFFFFF);

    // main table walk
    for (int v = 0; v < NV; v++) begin
      wr(V_ADDR[v], V_WD[v]);
      check(V_REQ[v], 32'(pad_out), 32'(V_EXP[v]));
    end

    // R10 idle cycles and reads leave latch unchanged
    rd(3'd2, r);
    repeat (3) @(negedge clk);
    check("R10 hold", 32'(pad_out), 32'h00EDCBA9);
    // R10 a dir write does not touch the latch
    wr(3'd1, 32'h000000FF);
    check("R10 dir only", 32'(pad_out), 32'h000000A9);
    wr(3'd1, 32'h00FFFFFF);
    check("R10 latch kept", 32'(pad_out), 32'h00EDCBA9);
    // R10 write to unmapped address has no effect
    wr(3'd6, 32'hFFFFFFFF);
    check("R10 unmapped wr", 32'(pad_out), 32'h00EDCBA9);
    rd(3'd1, r);
    check("R10 unmapped dir", r, 32'h00FFFFFF);

    // R6 command and unmapped reads are zero
    for (int a = 2; a < 8; a++) begin
      rd(3'(a), r);
      check("R6 read zero", r, 32'h0);
    end

    // R8 two-flop input latency
    @(negedge clk);
    pad_in = 24'h123456;
    addr = 3'd0;
    @(negedge clk);
    rd(3'd0, r);
    check("R8 one edge", r, 32'h0);
    @(negedge clk);
    rd(3'd0, r);
    check("R8 two edges", r, 32'h00123456);
    pad_in = 24'hFEDCBA;
    repeat (2) @(negedge clk);
    rd(3'd0, r);
    check("R8 second pattern", r, 32'h00FEDCBA);

    // R1 reset in the middle of activity
    rst_n = 1'b0;
    #5;
    check("R1 async oe", 32'(pad_oe), 32'h0);
    check("R1 async out", 32'(pad_out), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    wr(3'd1, 32'h00FFFFFF);
    check("R1 latch cleared", 32'(pad_out), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule